// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block sits beside the issue queue of an out-of-order core. It holds in-flight loads, stores and memory barriers and decides when each load or store may go to issue. An operation goes out only when two conditions both hold: its source registers are ready, and the store or barrier it waits on has completed. The producer an operation waits on comes from an active barrier when one applies. Otherwise it comes from a producing-store sequence number that an outside predictor supplies with the insert.

All requests arrive on one command port, one per cycle: insert, register-ready notice, completion, squash, reschedule and replay. Released operations leave one per cycle through a valid/ready output, always the oldest released sequence number first. Sequence numbers are unique among live entries and are compared as plain unsigned values.

Top module: `memdep_tracker`

## Requirements
- R1: Command codes on `cmdOp`: 0 insert, 1 register-ready notice, 2 completion, 3 squash, 4 reschedule, 5 replay. Kind codes on `cmdKind`: 0 load, 1 store, 2 full barrier, 3 write barrier. After reset `outValid` and `full` are low.
- R2: An inserted load or store has no dependence when its producer number is zero or names no live entry. It is then released on the next cycle if `cmdRegsReady` was high at insertion. If that flag was low, the operation waits for a register-ready notice.
- R3: An operation whose producer is live is not released until that producer completes. On completion, a waiting dependent with ready registers is released. A dependent without ready registers is only marked resolved, and it is released by its later register-ready notice.
- R4: An inserted full barrier makes later loads and stores depend on it. A write barrier makes later stores depend on it. Loads are not affected by a write barrier.
- R5: A completing barrier clears a barrier condition only when that condition still records the completing barrier's number. A newer barrier stays in force.
- R6: A register-ready notice for an entry whose registers are already marked ready has no effect.
- R7: A squash with number S removes every entry and every pending replay with a number greater than S, together with any of their queued releases. A later completion or replay releases none of them.
- R8: A reschedule marks a live load or store for replay. A replay releases every marked operation and clears all marks, so a second replay releases nothing.
- R9: A completed entry leaves the table. A later insert that names it as producer has no dependence.
- R10: `full` is high exactly when all entries are live. An insert while `full` is high is refused: nothing is stored and nothing is released.
- R11: At most one operation leaves per cycle. `outSeq` shows the smallest released sequence number. It is held while `outReady` is low, and it is removed from the queue when `outValid` and `outReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command code |
| cmdSeq | input | SEQ_W | Sequence number the command refers to |
| cmdKind | input | 2 | Operation kind for inserts |
| cmdPred | input | SEQ_W | Predicted producer number for inserts, zero for none |
| cmdRegsReady | input | 1 | Registers ready at insertion |
| full | output | 1 | No free entry |
| outValid | output | 1 | A released operation is offered |
| outSeq | output | SEQ_W | Sequence number of the offered operation |
| outReady | input | 1 | Issue side accepts the offered operation |

## Verification
If the ready or resolved flags are wrong, the output shows it one cycle after the command that should have released an operation. `outValid` either stays low where a release is due, or it rises for an operation still waiting. If the barrier records or the producer numbers are wrong, the effect appears only when the producer completes, as a wrong set of released numbers. A fault in the oldest-first selection or in squash removal shows up as a wrong `outSeq` in the cycles after the event, while the queue drains. The bench therefore compares the port values every cycle against a bench model.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD    = 2'd0,
    KIND_STORE   = 2'd1,
    KIND_FULLBAR = 2'd2,
    KIND_WRBAR   = 2'd3
  } opKind_t;

  typedef enum logic [2:0] {
    CMD_INSERT  = 3'd0,
    CMD_REGS    = 3'd1,
    CMD_DONE    = 3'd2,
    CMD_SQUASH  = 3'd3,
    CMD_RESCHED = 3'd4,
    CMD_REPLAY  = 3'd5
  } cmdOp_t;

  typedef struct packed {
    logic doInsert;
    logic insDepends;
    logic doNote;
    logic doDone;
    logic doWake;
    logic doSquash;
    logic doResched;
    logic doReplay;
  } strobe_t;

endpackage

// File: rtl/memdep_ctrl.sv
module memdep_ctrl
  import memdep_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [1:0]       cmdKind,
  input  logic [SEQ_W-1:0] cmdSeq,
  input  logic [SEQ_W-1:0] cmdPred,
  input  logic             full,
  input  logic             prodHit,
  input  logic             cmdHit,
  input  opKind_t          cmdHitKind,
  output strobe_t          stb,
  output logic [SEQ_W-1:0] depSeq,
  output logic             ldBarOn,
  output logic             stBarOn
);

  logic [SEQ_W-1:0] ldBarSeq;
  logic [SEQ_W-1:0] stBarSeq;
  opKind_t          insKind;
  cmdOp_t           op;
  logic             isIns;
  logic             insIsMem;

  assign insKind  = opKind_t'(cmdKind);
  assign op       = cmdOp_t'(cmdOp);
  assign isIns    = cmdValid && (op == CMD_INSERT) && !full;
  assign insIsMem = (insKind == KIND_LOAD) || (insKind == KIND_STORE);

  always_comb begin
    if (insKind == KIND_LOAD && ldBarOn)       depSeq = ldBarSeq;
    else if (insKind == KIND_STORE && stBarOn) depSeq = stBarSeq;
    else                                       depSeq = cmdPred;
  end

  always_comb begin
    stb            = '0;
    stb.doInsert   = isIns;
    stb.insDepends = insIsMem && (depSeq != '0) && prodHit;
    stb.doNote     = cmdValid && (op == CMD_REGS);
    stb.doDone     = cmdValid && (op == CMD_DONE) && cmdHit;
    stb.doWake     = stb.doDone && (cmdHitKind != KIND_LOAD);
    stb.doSquash   = cmdValid && (op == CMD_SQUASH);
    stb.doResched  = cmdValid && (op == CMD_RESCHED);
    stb.doReplay   = cmdValid && (op == CMD_REPLAY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldBarOn  <= 1'b0;
      stBarOn  <= 1'b0;
      ldBarSeq <= '0;
      stBarSeq <= '0;
    end else begin
      if (isIns && insKind == KIND_FULLBAR) begin
        ldBarOn  <= 1'b1;
        ldBarSeq <= cmdSeq;
        stBarOn  <= 1'b1;
        stBarSeq <= cmdSeq;
      end else if (isIns && insKind == KIND_WRBAR) begin
        stBarOn  <= 1'b1;
        stBarSeq <= cmdSeq;
      end
      if (stb.doDone && cmdHitKind == KIND_FULLBAR) begin
        if (ldBarSeq == cmdSeq) ldBarOn <= 1'b0;
        if (stBarSeq == cmdSeq) stBarOn <= 1'b0;
      end else if (stb.doDone && cmdHitKind == KIND_WRBAR) begin
        if (stBarSeq == cmdSeq) stBarOn <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/memdep_table.sv
module memdep_table
  import memdep_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SEQ_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [SEQ_W-1:0] cmdSeq,
  input  logic [1:0]       cmdKind,
  input  logic             cmdRegsReady,
  input  logic [SEQ_W-1:0] depSeq,
  input  logic             outReady,
  output logic             prodHit,
  output logic             cmdHit,
  output opKind_t          cmdHitKind,
  output logic             full,
  output logic             outValid,
  output logic [SEQ_W-1:0] outSeq
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, pend, inRep, memRdy, regRdy;
  logic [SEQ_W-1:0]   seqArr [ENTRIES];
  logic [SEQ_W-1:0]   depArr [ENTRIES];
  opKind_t            kindArr[ENTRIES];

  logic [ENTRIES-1:0] hitCmd, hitProd, hitWake, hitSquash, memKind;
  logic [IDX_W-1:0]   freeIdx, popIdx;
  logic               pop;
  opKind_t            newKind;
  logic               newIsMem;

  assign newKind  = opKind_t'(cmdKind);
  assign newIsMem = (newKind == KIND_LOAD) || (newKind == KIND_STORE);

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign hitCmd[g]    = vld[g] && (seqArr[g] == cmdSeq);
    assign hitProd[g]   = vld[g] && (seqArr[g] == depSeq);
    assign hitWake[g]   = vld[g] && !memRdy[g] && (depArr[g] == cmdSeq);
    assign hitSquash[g] = vld[g] && (seqArr[g] > cmdSeq);
    assign memKind[g]   = (kindArr[g] == KIND_LOAD) || (kindArr[g] == KIND_STORE);
  end

  assign full    = &vld;
  assign prodHit = |hitProd;
  assign cmdHit  = |hitCmd;
  assign pop     = outValid && outReady;

  always_comb begin
    freeIdx    = '0;
    cmdHitKind = KIND_LOAD;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) freeIdx = IDX_W'(i);
      if (hitCmd[i]) cmdHitKind = kindArr[i];
    end
  end

  always_comb begin
    outValid = 1'b0;
    outSeq   = '0;
    popIdx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && pend[i] && (!outValid || seqArr[i] < outSeq)) begin
        outValid = 1'b1;
        outSeq   = seqArr[i];
        popIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      pend   <= '0;
      inRep  <= '0;
      memRdy <= '0;
      regRdy <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        seqArr[i]  <= '0;
        depArr[i]  <= '0;
        kindArr[i] <= KIND_LOAD;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (pop && popIdx == IDX_W'(i)) pend[i] <= 1'b0;
        if (stb.doInsert && freeIdx == IDX_W'(i)) begin
          vld[i]     <= 1'b1;
          kindArr[i] <= newKind;
          seqArr[i]  <= cmdSeq;
          depArr[i]  <= depSeq;
          regRdy[i]  <= cmdRegsReady;
          memRdy[i]  <= !stb.insDepends;
          pend[i]    <= newIsMem && !stb.insDepends && cmdRegsReady;
          inRep[i]   <= 1'b0;
        end
        if (stb.doNote && hitCmd[i] && memKind[i] && !regRdy[i]) begin
          regRdy[i] <= 1'b1;
          if (memRdy[i]) pend[i] <= 1'b1;
        end
        if (stb.doWake && hitWake[i]) begin
          memRdy[i] <= 1'b1;
          if (regRdy[i]) pend[i] <= 1'b1;
        end
        if (stb.doResched && hitCmd[i] && memKind[i]) inRep[i] <= 1'b1;
        if (stb.doReplay && inRep[i]) begin
          pend[i]  <= 1'b1;
          inRep[i] <= 1'b0;
        end
        if ((stb.doDone && hitCmd[i]) || (stb.doSquash && hitSquash[i])) begin
          vld[i]   <= 1'b0;
          pend[i]  <= 1'b0;
          inRep[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
  import memdep_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SEQ_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [SEQ_W-1:0] cmdSeq,
  input  logic [1:0]       cmdKind,
  input  logic [SEQ_W-1:0] cmdPred,
  input  logic             cmdRegsReady,
  output logic             full,
  output logic             outValid,
  output logic [SEQ_W-1:0] outSeq,
  input  logic             outReady
);

  strobe_t          stb;
  logic [SEQ_W-1:0] depSeq;
  logic             prodHit, cmdHit, ldBarOn, stBarOn;
  opKind_t          cmdHitKind;

  memdep_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdKind(cmdKind), .cmdSeq(cmdSeq), .cmdPred(cmdPred), .full(full),
    .prodHit(prodHit), .cmdHit(cmdHit), .cmdHitKind(cmdHitKind),
    .stb(stb), .depSeq(depSeq), .ldBarOn(ldBarOn), .stBarOn(stBarOn)
  );

  memdep_table #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_table (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cmdSeq(cmdSeq), .cmdKind(cmdKind),
    .cmdRegsReady(cmdRegsReady), .depSeq(depSeq), .outReady(outReady),
    .prodHit(prodHit), .cmdHit(cmdHit), .cmdHitKind(cmdHitKind),
    .full(full), .outValid(outValid), .outSeq(outSeq)
  );

endmodule

// File: rtl/memdep_checks.sv
module memdep_checks #(
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic [SEQ_W-1:0] cmdSeq,
  input logic [1:0]       cmdKind,
  input logic [SEQ_W-1:0] cmdPred,
  input logic             cmdRegsReady,
  input logic             full,
  input logic             outValid,
  input logic [SEQ_W-1:0] outSeq,
  input logic             outReady,
  input logic             ldBarOn
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!outValid && !full); // R1
    end
  end

  AST_NODEP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdOp == 3'd0 && cmdKind == 2'd0 && !ldBarOn && cmdPred == '0
      && cmdRegsReady && !full
    |=> outValid && outSeq <= $past(cmdSeq)); // R2

  AST_FULLBAR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdOp == 3'd0 && cmdKind == 2'd2 && !full |=> ldBarOn); // R4

  AST_SQUASH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdOp == 3'd3 |=> !outValid || outSeq <= $past(cmdSeq)); // R7

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    full && cmdValid && cmdOp == 3'd0 |=> full); // R10

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady && !cmdValid |=> outValid && $stable(outSeq)); // R11

  AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady && !(cmdValid && cmdOp == 3'd5)
    |=> !outValid || outSeq != $past(outSeq)); // R11

endmodule

bind memdep_tracker memdep_checks #(.SEQ_W(SEQ_W)) u_checks (.*);

// File: tb/memdep_tracker_bench.sv
module memdep_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [SW-1:0] cmdSeq = '0;
  logic [1:0]    cmdKind = '0;
  logic [SW-1:0] cmdPred = '0;
  logic          cmdRegsReady = 1'b0;
  logic          full, outValid, outReady = 1'b0;
  logic [SW-1:0] outSeq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memdep_tracker #(.ENTRIES(N), .SEQ_W(SW)) u_memdep_tracker (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSeq(cmdSeq), .cmdKind(cmdKind), .cmdPred(cmdPred),
    .cmdRegsReady(cmdRegsReady), .full(full), .outValid(outValid),
    .outSeq(outSeq), .outReady(outReady)
  );

  // bench model state
  bit          mV[N], mMem[N], mReg[N], mPend[N], mRep[N];
  int unsigned mSeq[N], mDep[N], mKind[N];
  bit          ldOn, stOn;
  int unsigned ldSeq, stSeq;

  function automatic void modelOut(output bit v, output int unsigned s);
    v = 0; s = 0;
    for (int i = 0; i < N; i++)
      if (mV[i] && mPend[i] && (!v || mSeq[i] < s)) begin v = 1; s = mSeq[i]; end
  endfunction

  function automatic bit modelFull();
    for (int i = 0; i < N; i++) if (!mV[i]) return 0;
    return 1;
  endfunction

  function automatic int findSeq(int unsigned s);
    for (int i = 0; i < N; i++) if (mV[i] && mSeq[i] == s) return i;
    return -1;
  endfunction

  function automatic void modelStep(bit v, int op, int unsigned s, int k,
                                    int unsigned p, bit regs, bit rdy);
    bit ov; int unsigned os; int idx; int unsigned dep; bit dp;
    modelOut(ov, os);
    if (ov && rdy) mPend[findSeq(os)] = 0;
    if (!v) return;
    idx = findSeq(s);
    case (op)
      0: if (!modelFull()) begin
           if (k == 0 && ldOn) dep = ldSeq;
           else if (k == 1 && stOn) dep = stSeq;
           else dep = p;
           dp = (k < 2) && dep != 0 && findSeq(dep) >= 0;
           if (k == 2) begin ldOn = 1; ldSeq = s; stOn = 1; stSeq = s; end
           if (k == 3) begin stOn = 1; stSeq = s; end
           for (int i = 0; i < N; i++) if (!mV[i]) begin
             mV[i] = 1; mSeq[i] = s; mKind[i] = k; mDep[i] = dep;
             mReg[i] = regs; mMem[i] = !dp; mPend[i] = (k < 2) && !dp && regs;
             mRep[i] = 0; break;
           end
         end
      1: if (idx >= 0 && mKind[idx] < 2 && !mReg[idx]) begin
           mReg[idx] = 1; if (mMem[idx]) mPend[idx] = 1;
         end
      2: if (idx >= 0) begin
           if (mKind[idx] != 0)
             for (int i = 0; i < N; i++)
               if (mV[i] && !mMem[i] && mDep[i] == s) begin
                 mMem[i] = 1; if (mReg[i]) mPend[i] = 1;
               end
           if (mKind[idx] == 2) begin
             if (ldSeq == s) ldOn = 0;
             if (stSeq == s) stOn = 0;
           end else if (mKind[idx] == 3 && stSeq == s) stOn = 0;
           mV[idx] = 0; mPend[idx] = 0; mRep[idx] = 0;
         end
      3: for (int i = 0; i < N; i++)
           if (mV[i] && mSeq[i] > s) begin mV[i] = 0; mPend[i] = 0; mRep[i] = 0; end
      4: if (idx >= 0 && mKind[idx] < 2) mRep[idx] = 1;
      5: for (int i = 0; i < N; i++)
           if (mRep[i]) begin mPend[i] = 1; mRep[i] = 0; end
      default: ;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(bit v, int op, int unsigned s, int k, int unsigned p,
                     bit regs, bit rdy);
    bit ov; int unsigned os;
    cmdValid = v; cmdOp = 3'(op); cmdSeq = SW'(s); cmdKind = 2'(k);
    cmdPred = SW'(p); cmdRegsReady = regs; outReady = rdy;
    modelStep(v, op, s, k, p, regs, rdy);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 0; outReady = 0;
    modelOut(ov, os);
    check(outValid == ov, "R11 model valid", int'(outValid), int'(ov));
    if (ov) check(outSeq == SW'(os), "R11 model seq", int'(outSeq), int'(os));
    check(full == modelFull(), "R10 model full", int'(full), int'(modelFull()));
  endtask

  task automatic ins(int unsigned s, int k, int unsigned p, bit regs);
    cyc(1, 0, s, k, p, regs, 0);
  endtask
  task automatic cmd(int op, int unsigned s);
    cyc(1, op, s, 0, 0, 0, 0);
  endtask
  task automatic popc();
    cyc(0, 0, 0, 0, 0, 0, 1);
  endtask
  task automatic expOut(bit v, int unsigned s, string req);
    check(outValid == v, req, int'(outValid), int'(v));
    if (v) check(outSeq == SW'(s), req, int'(outSeq), int'(s));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int unsigned nextSeq; int r, op, k;
    int unsigned s, p;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin mV[i] = 0; mPend[i] = 0; mRep[i] = 0; end
    ldOn = 0; stOn = 0; ldSeq = 0; stSeq = 0;
    repeat (3) @(negedge clk);
    check(!outValid && !full, "R1 reset state", int'(outValid) + int'(full), 0);
    rst_n = 1'b1;
    @(negedge clk);

    ins(10, 0, 0, 1);  expOut(1, 10, "R2 no-dep load released");
    popc();            expOut(0, 0, "R11 popped");
    ins(20, 1, 0, 0);  expOut(0, 0, "R2 regs not ready held");
    cmd(1, 20);        expOut(1, 20, "R2 notice releases");
    popc();
    cmd(1, 20);        expOut(0, 0, "R6 duplicate notice ignored");
    ins(30, 0, 20, 1); expOut(0, 0, "R3 waits on live producer");
    ins(31, 0, 20, 0);
    cmd(2, 20);        expOut(1, 30, "R3 completion wakes ready dependent");
    popc();            expOut(0, 0, "R3 unready dependent only resolved");
    cmd(1, 31);        expOut(1, 31, "R3 notice after wake releases");
    popc();
    ins(40, 0, 99, 1); expOut(1, 40, "R2 absent producer no dependence");
    popc();
    ins(50, 2, 0, 0);
    ins(51, 0, 0, 1);  expOut(0, 0, "R4 full barrier holds load");
    ins(52, 1, 0, 1);  expOut(0, 0, "R4 full barrier holds store");
    ins(53, 3, 0, 0);
    cmd(2, 50);        expOut(1, 51, "R4 barrier completion wakes");
    popc();            expOut(1, 52, "R4 second dependent");
    popc();
    ins(55, 0, 0, 1);  expOut(1, 55, "R4 load ignores write barrier");
    popc();
    ins(56, 1, 0, 1);  expOut(0, 0, "R5 newer write barrier stays");
    cmd(2, 53);        expOut(1, 56, "R5 write barrier completion");
    popc();
    ins(58, 1, 0, 0);
    ins(60, 0, 58, 1); ins(61, 0, 58, 1); ins(62, 1, 58, 1);
    cmd(2, 58);        expOut(1, 60, "R11 oldest first");
    cyc(0, 0, 0, 0, 0, 0, 0); expOut(1, 60, "R11 held while not ready");
    popc();            expOut(1, 61, "R11 next oldest");
    popc();            expOut(1, 62, "R11 last");
    popc();
    cmd(4, 62); cmd(4, 60);
    cmd(5, 0);         expOut(1, 60, "R8 replay releases");
    popc();            expOut(1, 62, "R8 replay second");
    popc();
    cmd(5, 0);         expOut(0, 0, "R8 list emptied");
    cmd(4, 61);
    ins(70, 0, 0, 0); ins(71, 1, 0, 1); ins(72, 0, 71, 1);
    cmd(3, 60);        expOut(0, 0, "R7 squash drops queued release");
    cmd(5, 0);         expOut(0, 0, "R7 squash drops replay item");
    cmd(2, 71);        expOut(0, 0, "R7 removed dependent not woken");
    cmd(2, 60);
    ins(80, 0, 60, 1); expOut(1, 80, "R9 completed producer gone");
    popc();
    cmd(3, 0);
    for (int i = 0; i < N; i++) ins(100 + i, 0, 0, 0);
    check(full == 1'b1, "R10 full asserted", int'(full), 1);
    ins(116, 0, 0, 1); expOut(0, 0, "R10 refused insert");
    cmd(1, 116);       expOut(0, 0, "R10 refused entry absent");
    cmd(2, 100);
    check(full == 1'b0, "R10 full drops", int'(full), 0);
    cmd(3, 0);

    nextSeq = 200;
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom % 100);
      s = nextSeq - 1 - ($urandom % 10);
      if (r < 35) begin
        k = int'($urandom % 20);
        k = (k < 9) ? 0 : (k < 18) ? 1 : (k == 18) ? 2 : 3;
        p = ($urandom % 2) ? 0 : nextSeq - 1 - ($urandom % 8);
        cyc(1, 0, nextSeq, k, p, 1'($urandom), 1'($urandom % 10 < 7));
        nextSeq++;
      end else begin
        op = (r < 55) ? 1 : (r < 76) ? 2 : (r < 83) ? 4 : (r < 89) ? 5 : (r < 91) ? 3 : 6;
        if (op == 3) s = nextSeq - 1 - ($urandom % 6);
        if (op == 6) cyc(0, 0, 0, 0, 0, 0, 1'($urandom % 10 < 7));
        else cyc(1, op, s, 0, 0, 0, 1'($urandom % 10 < 7));
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule